// File: doc/BRIEF.md
# Mode-Selectable Polynomial Audio Waveform Generator

This block turns a 4-bit mode code into a one-bit audio waveform. Two short shift registers produce it: a 5-bit register that always runs as a polynomial counter, and a 4-bit register whose feedback source and advance condition the mode chooses. Depending on the mode, the output is a constant level, a square wave, an uneven pulse train, a short or long noise sequence, or a combination of these. Each of these has a fixed bit pattern and a fixed period. The periods are 1, 2, 6, 15, 31, 93, 465 and 511 steps.

The generator advances by one step on each clock edge where `tick` is high. In the enclosing design, `tick` is the output pulse of a frequency divider. Volume, channel mixing and conversion to an analog level all take place downstream of this block. The mode can change at any time. The new mode applies from the next tick, and the register contents are not reloaded.

Top module: `audio_wave_gen`

## Requirements
- R1: While `rst_n` is low, the 5-bit register holds 5'b00011 and the 4-bit register holds 4'b1111. `waveOut` is 0 during reset and just after it.
- R2: On a clock edge with `tick` low, no state changes. `waveOut` keeps its value until the next edge with `tick` high.
- R3: Modes 4'b0000 and 4'b1011 settle to a constant `waveOut` of 0, which is a period of 1.
- R4: Mode 4'b0001 repeats with period 15. One period, rotated, reads 000011101100101.
- R5: Modes 4'b0100 and 4'b0101 toggle `waveOut` on every tick, giving the pattern 01.
- R6: Modes 4'b0110 and 4'b1010 repeat with period 31. Each period is a run of 13 zeros followed by a run of 18 ones.
- R7: Mode 4'b1001 repeats with period 31. One period, rotated, reads 0000011100100010101111011010011.
- R8: Mode 4'b0111 repeats with period 31. One period, rotated, reads 0000100101100111110001101110101.
- R9: Mode 4'b1000 links both registers into a 9-bit noise sequence with an exact period of 511.
- R10: Modes 4'b1100 and 4'b1101 give the pattern 000111. Mode 4'b1110 gives period 93, made of 44 zeros then 49 ones. Mode 4'b1111 has an exact period of 93.
- R11: Modes 4'b0010 and 4'b0011 both have an exact period of 465.
- R12: A mode change takes effect at the first tick after it and does not reload either register.
- R13: The 5-bit register shifts one place toward bit 0 on every tick, in every mode.
- R14: When the mode's low bits are 2'b11, the 4-bit register advances only on ticks where bit 0 of the 5-bit register is 1. When they are 2'b10, it advances only on ticks where the 5-bit register holds 5'b00011 or 5'b10010.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset that loads the seeds |
| tick | input | 1 | Step enable from the upstream divider |
| mode | input | 4 | Waveform selection code |
| waveOut | output | 1 | One-bit waveform |

## Verification
The uneven tone modes are the most sensitive case. If the gating states of the 5-bit register were decoded wrongly, the two runs would swap lengths (18 zeros and 13 ones) or would not add up to 31. The long-period modes are checked for their exact minimal period, so a feedback tap in the wrong place, which would shorten the 465, 511 or 93 cycle, is caught. Mid-run mode switches are compared step by step against a reference model, which exposes any design that reloads the seeds or applies the new mode one tick late. Idle cycles with `tick` low confirm that nothing moves between ticks.

// File: rtl/audio_wave_pkg.sv
package audio_wave_pkg;

  localparam int PULSE_W   = 4;
  localparam int NOISE_W   = 5;
  localparam int MODE_W    = 4;
  localparam int NOISE_TAP = 2;

  // Strobes and feedback bits from control to datapath
  typedef struct packed {
    logic noiseStep;
    logic pulseStep;
    logic noiseIn;
    logic pulseIn;
  } stepCtrl_t;

  // Upper mode bits: feedback source of the 4-bit register
  typedef enum logic [1:0] {
    PSRC_POLY4  = 2'd0,
    PSRC_TOGGLE = 2'd1,
    PSRC_NOISE  = 2'd2,
    PSRC_DIV6   = 2'd3
  } pulseSrc_e;

  // Lower mode bits: advance gate of the 4-bit register and 5-bit feedback
  typedef enum logic [1:0] {
    GATE_FREE_LINK = 2'd0,
    GATE_FREE      = 2'd1,
    GATE_PAIR      = 2'd2,
    GATE_NOISE     = 2'd3
  } gate_e;

endpackage

// File: rtl/audio_wave_ctrl.sv
module audio_wave_ctrl
  import audio_wave_pkg::*;
#(
  parameter logic [NOISE_W-1:0] PAIR_A     = 5'b00011,
  parameter logic [NOISE_W-1:0] PAIR_B     = 5'b10010,
  parameter logic [PULSE_W-1:0] TRAP_STATE = 4'b1010
) (
  input  logic               tick,
  input  logic [MODE_W-1:0]  mode,
  input  logic [NOISE_W-1:0] noiseState,
  input  logic [PULSE_W-1:0] pulseState,
  output stepCtrl_t          ctrl
);

  pulseSrc_e srcSel;
  gate_e     gateSel;
  logic      holdPulse;
  logic      noiseFb;
  logic      pulseFb;
  logic      noiseZero;
  logic      pulseTrap;

  assign srcSel    = pulseSrc_e'(mode[MODE_W-1:MODE_W-2]);
  assign gateSel   = gate_e'(mode[1:0]);
  assign noiseZero = (noiseState == '0);
  assign pulseTrap = (pulseState == TRAP_STATE);

  // Advance gate of the 4-bit register
  always_comb begin
    unique case (gateSel)
      GATE_PAIR:  holdPulse = !((noiseState == PAIR_A) || (noiseState == PAIR_B));
      GATE_NOISE: holdPulse = !noiseState[0];
      default:    holdPulse = 1'b0;
    endcase
  end

  // Feedback into the top of the 5-bit register
  always_comb begin
    if (gateSel == GATE_FREE_LINK) begin
      noiseFb = (pulseState[0] ^ noiseState[0])
              | (noiseZero & pulseTrap)
              | (srcSel == PSRC_POLY4);
    end else begin
      noiseFb = (noiseState[NOISE_TAP] ^ noiseState[0]) | noiseZero;
    end
  end

  // Feedback into the top of the 4-bit register
  always_comb begin
    unique case (srcSel)
      PSRC_POLY4:  pulseFb = (pulseState[1] ^ pulseState[0]) & !pulseTrap
                           & (gateSel != GATE_FREE_LINK);
      PSRC_TOGGLE: pulseFb = !pulseState[PULSE_W-1];
      PSRC_NOISE:  pulseFb = !noiseState[0];
      default:     pulseFb = !pulseState[1] & (pulseState[PULSE_W-1:1] != '0);
    endcase
  end

  always_comb begin
    ctrl.noiseStep = tick;
    ctrl.pulseStep = tick & !holdPulse;
    ctrl.noiseIn   = noiseFb;
    ctrl.pulseIn   = pulseFb;
  end

endmodule

// File: rtl/audio_wave_dpath.sv
module audio_wave_dpath
  import audio_wave_pkg::*;
#(
  parameter logic [PULSE_W-1:0] PULSE_SEED = 4'b1111,
  parameter logic [NOISE_W-1:0] NOISE_SEED = 5'b00011
) (
  input  logic               clk,
  input  logic               rst_n,
  input  stepCtrl_t          ctrl,
  output logic [NOISE_W-1:0] noiseState,
  output logic [PULSE_W-1:0] pulseState,
  output logic               waveOut
);

  logic [PULSE_W-1:0] pulseNext;
  logic [NOISE_W-1:0] noiseNext;

  // Lower bits of the 4-bit register take the complement of their upper neighbour
  for (genvar i = 0; i < PULSE_W - 1; i++) begin : g_pulseShift
    assign pulseNext[i] = ~pulseState[i+1];
  end
  assign pulseNext[PULSE_W-1] = ctrl.pulseIn;

  assign noiseNext = {ctrl.noiseIn, noiseState[NOISE_W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      noiseState <= NOISE_SEED;
      pulseState <= PULSE_SEED;
    end else begin
      if (ctrl.noiseStep) noiseState <= noiseNext;
      if (ctrl.pulseStep) pulseState <= pulseNext;
    end
  end

  // Stored value is the complement of the waveform level
  assign waveOut = ~pulseState[0];

endmodule

// File: rtl/audio_wave_gen.sv
module audio_wave_gen
  import audio_wave_pkg::*;
#(
  parameter logic [PULSE_W-1:0] PULSE_SEED = 4'b1111,
  parameter logic [NOISE_W-1:0] NOISE_SEED = 5'b00011,
  parameter logic [NOISE_W-1:0] PAIR_A     = 5'b00011,
  parameter logic [NOISE_W-1:0] PAIR_B     = 5'b10010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [MODE_W-1:0] mode,
  output logic              waveOut
);

  stepCtrl_t          ctrl;
  logic [NOISE_W-1:0] noiseState;
  logic [PULSE_W-1:0] pulseState;

  audio_wave_ctrl #(
    .PAIR_A (PAIR_A),
    .PAIR_B (PAIR_B)
  ) u_ctrl (
    .tick       (tick),
    .mode       (mode),
    .noiseState (noiseState),
    .pulseState (pulseState),
    .ctrl       (ctrl)
  );

  audio_wave_dpath #(
    .PULSE_SEED (PULSE_SEED),
    .NOISE_SEED (NOISE_SEED)
  ) u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl       (ctrl),
    .noiseState (noiseState),
    .pulseState (pulseState),
    .waveOut    (waveOut)
  );

endmodule

// File: rtl/audio_wave_chk.sv
module audio_wave_chk
  import audio_wave_pkg::*;
#(
  parameter logic [PULSE_W-1:0] PULSE_SEED = 4'b1111,
  parameter logic [NOISE_W-1:0] NOISE_SEED = 5'b00011
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick,
  input logic [MODE_W-1:0]  mode,
  input logic               waveOut,
  input logic [NOISE_W-1:0] noiseState,
  input logic [PULSE_W-1:0] pulseState
);

  // R1: seeds present when reset is released
  assert_reset_seed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (noiseState == NOISE_SEED) && (pulseState == PULSE_SEED) && !waveOut);

  // R2: an edge without tick leaves everything in place
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(noiseState) && $stable(pulseState) && $stable(waveOut));

  // R3: the settled constant state of modes 0000 and 1011 is kept
  assert_const_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick && ((mode == 4'b0000) || (mode == 4'b1011)) && (pulseState == 4'd5)
    |=> (pulseState == 4'd5) && !waveOut);

  // R5: square-wave modes flip the output each tick once in the two-state loop
  assert_square_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick && (mode[3:1] == 3'b010) && ((pulseState == '0) || (pulseState == '1))
    |=> waveOut != $past(waveOut));

  // R13: the 5-bit register shifts toward bit 0 on every tick
  assert_noise_shift_R13: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> noiseState[NOISE_W-2:0] == $past(noiseState[NOISE_W-1:1]));

  // R14: low bits 11 hold the 4-bit register while noise bit 0 is low
  assert_gate_noise_R14: assert property (@(posedge clk) disable iff (!rst_n)
    tick && (mode[1:0] == 2'b11) && !noiseState[0] |=> $stable(pulseState));

  // R14: low bits 10 hold the 4-bit register outside the two gate states
  assert_gate_pair_R14: assert property (@(posedge clk) disable iff (!rst_n)
    tick && (mode[1:0] == 2'b10) && (noiseState != 5'b00011) && (noiseState != 5'b10010)
    |=> $stable(pulseState));

endmodule

bind audio_wave_gen audio_wave_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .mode       (mode),
  .waveOut    (waveOut),
  .noiseState (noiseState),
  .pulseState (pulseState)
);

// File: tb/sim_audio_wave_gen.sv
module sim_audio_wave_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [3:0] mode = 4'b0000;
  logic       waveOut;

  always #10 clk = ~clk;

  audio_wave_gen u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .mode    (mode),
    .waveOut (waveOut)
  );

  int    errors = 0;
  int    checks = 0;
  int    refNoise = 3;
  int    refPulse = 15;
  string tag = "R1";
  bit    samples[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference: one step of both registers
  function automatic void refStep(input int md, inout int nz, inout int pu);
    int lo = md % 4;
    int hi = md / 4;
    int nb = nz % 2;
    int hold;
    int nf;
    int pf;
    if (lo == 2)      hold = (nz == 3 || nz == 18) ? 0 : 1;
    else if (lo == 3) hold = (nb == 1) ? 0 : 1;
    else              hold = 0;
    if (lo == 0) nf = (((pu % 2) != nb) || (nz == 0 && pu == 10) || hi == 0) ? 1 : 0;
    else         nf = ((((nz / 4) % 2) != nb) || nz == 0) ? 1 : 0;
    case (hi)
      0: pf = ((((pu / 2) % 2) != (pu % 2)) && pu != 10 && lo != 0) ? 1 : 0;
      1: pf = (pu >= 8) ? 0 : 1;
      2: pf = (nb == 1) ? 0 : 1;
      default: pf = (((pu / 2) % 2) == 0 && (pu / 2) != 0) ? 1 : 0;
    endcase
    nz = nz / 2 + nf * 16;
    if (hold == 0) pu = (7 - (pu / 2) % 8) + pf * 8;
  endfunction

  function automatic int refOut();
    return (refPulse % 2 == 1) ? 0 : 1;
  endfunction

  // One clock: inputs driven at a falling edge, output sampled at the next one
  task automatic step(input bit t, input bit rec);
    tick = t;
    if (t) refStep(int'(mode), refNoise, refPulse);
    @(negedge clk);
    check(int'(waveOut) == refOut(), tag, "model compare", int'(waveOut), refOut());
    if (rec) samples.push_back(waveOut);
  endtask

  task automatic doReset(input logic [3:0] md);
    @(negedge clk);
    rst_n = 1'b0;
    tick  = 1'b1;
    mode  = md;
    repeat (3) @(negedge clk);
    tick     = 1'b0;
    refNoise = 3;
    refPulse = 15;
    rst_n    = 1'b1;
  endtask

  function automatic string runs(input int zeros, input int ones);
    string s = "";
    for (int k = 0; k < zeros; k++) s = {s, "0"};
    for (int k = 0; k < ones; k++)  s = {s, "1"};
    return s;
  endfunction

  function automatic bit rotMatch(input string pat, input int per);
    for (int r = 0; r < per; r++) begin
      bit ok = 1'b1;
      for (int k = 0; k < per; k++)
        if (samples[(k + r) % per] != (pat[k] == "1")) ok = 1'b0;
      if (ok) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic runMode(input logic [3:0] md, input int per, input string pat,
                         input string req);
    bit periodic = 1'b1;
    bit shorter  = 1'b0;
    tag = req;
    doReset(md);
    repeat (64) step(1'b1, 1'b0);
    samples.delete();
    repeat (2 * per) step(1'b1, 1'b1);
    for (int k = 0; k < per; k++)
      if (samples[k] != samples[k + per]) periodic = 1'b0;
    check(periodic, req, $sformatf("mode %b repeats with period", md), periodic, 1);
    for (int d = 1; d < per; d++) begin
      if (per % d == 0) begin
        bit same = 1'b1;
        for (int k = 0; k < per; k++)
          if (samples[k] != samples[k + d]) same = 1'b0;
        if (same) shorter = 1'b1;
      end
    end
    check(!shorter, req, $sformatf("mode %b has no shorter period than %0d", md, per),
          shorter, 0);
    if (pat.len() == per)
      check(rotMatch(pat, per), req, $sformatf("mode %b pattern match", md),
            rotMatch(pat, per), 1);
  endtask

  initial begin : watchdog
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    // R1: reset state
    doReset(4'b0000);
    tag = "R1";
    check(waveOut == 1'b0, "R1", "output after reset", int'(waveOut), 0);

    // R2: idle edges hold the output
    doReset(4'b0100);
    tag = "R2";
    step(1'b1, 1'b0);
    for (int k = 0; k < 5; k++) begin
      step(1'b0, 1'b0);
      check(waveOut == 1'b1, "R2", "held output with tick low", int'(waveOut), 1);
    end
    step(1'b1, 1'b0);
    check(waveOut == 1'b0, "R2", "output moves on next tick", int'(waveOut), 0);
    for (int k = 0; k < 40; k++) step((k % 3) == 0, 1'b0);

    runMode(4'b0000, 1,   "0", "R3");
    runMode(4'b1011, 1,   "0", "R3");
    runMode(4'b0001, 15,  "000011101100101", "R4");
    runMode(4'b0100, 2,   "01", "R5");
    runMode(4'b0101, 2,   "01", "R5");
    runMode(4'b0110, 31,  runs(13, 18), "R6");
    runMode(4'b1010, 31,  runs(13, 18), "R6");
    runMode(4'b1001, 31,  "0000011100100010101111011010011", "R7");
    runMode(4'b0111, 31,  "0000100101100111110001101110101", "R8");
    runMode(4'b1000, 511, "", "R9");
    runMode(4'b1100, 6,   "000111", "R10");
    runMode(4'b1101, 6,   "000111", "R10");
    runMode(4'b1110, 93,  runs(44, 49), "R10");
    runMode(4'b1111, 93,  "", "R10");
    runMode(4'b0010, 465, "", "R11");
    runMode(4'b0011, 465, "", "R11");

    // R12: switch modes mid-run without reset; R13/R14 gating is covered by the model
    doReset(4'b0001);
    tag = "R12";
    repeat (10) step(1'b1, 1'b0);
    mode = 4'b1001;
    repeat (37) step(1'b1, 1'b0);
    mode = 4'b0110;
    repeat (70) step(1'b1, 1'b0);
    mode = 4'b1111;
    for (int k = 0; k < 60; k++) step((k % 2) == 0, 1'b0);
    mode = 4'b1000;
    repeat (50) step(1'b1, 1'b0);
    tag = "R14";
    mode = 4'b0011;
    repeat (80) step(1'b1, 1'b0);
    mode = 4'b1010;
    repeat (80) step(1'b1, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule